// File: doc/BRIEF.md
# Legacy Peripheral Bus Decoder and Buffer Controller

This block sits beside a legacy ISA-style expansion bus and watches its address lines, command strobes and DMA acknowledges. For I/O cycles it produces active-low selects for a keyboard controller, an embedded microcontroller and a real-time clock. For memory cycles it produces an active-low select for a boot ROM. It also drives the controls of an 8-bit data buffer that joins a secondary peripheral bus to the system data bus: an output enable and a direction control. It also produces the address-latch strobe that captures a register index in the real-time clock.

The chip selects are decoded combinationally from the address and the active command. The buffer controls and the latch strobe are registered. They react to command and acknowledge edges, which are sampled on the block clock. The length of the latch strobe is counted in system-clock ticks, which come in as a one-cycle pulse. Per-device decode-enable bits gate both the selects and the buffer enable. An initiator input selects how an open buffer enable closes: a bridge-owned cycle closes it at the end of the command, and an external-master cycle closes it when the address stops decoding. Any output can be taken over as a general-purpose output through its own mode bit.

Top module: `legacy_bus_decoder`

## Requirements
- R1: While reset is held and after it is released, with no command active, all four chip selects, `buf_oe_n` and `buf_dir_n` are high and `rtc_ale` is low.
- R2: `kbc_cs_n` is low only while an I/O command (`ior_n` or `iow_n` low) is active, address bits [15:0] equal 0060h or 0064h, and `dec_en[0]` is set. Memory commands never assert it, and at most one chip select is low at a time.
- R3: `mc_cs_n` is low only while an I/O command is active, address bits [15:0] equal 0062h or 0066h, and `dec_en[1]` is set.
- R4: `rtc_cs_n` is low only for an I/O command to address 0071h with `dec_en[2]` set. The index port 0070h does not assert it.
- R5: `rom_cs_n` is low only while a memory command (`memr_n` or `memw_n` low) is active, the full address lies in ROM_LO..ROM_HI (default 0E0000h..0FFFFFh), `dec_en[3]` is set, and no `dack_n` bit is low.
- R6: A falling `iow_n` sampled with address 0070h and `dec_en[2]` set drives `rtc_ale` high from the next clock. The strobe stays high until two `sys_tick` pulses have been sampled, and it goes low after the clock that samples the second one. A write to any other address does not start it.
- R7: `buf_dir_n` goes low on the clock that samples a falling `ior_n`, whatever the address. It returns high on the clock that samples the rising `ior_n`.
- R8: A falling `memr_n` drives `buf_dir_n` low only when the address lies in the ROM range and no DMA acknowledge is active. Otherwise the direction stays high.
- R9: For channels marked in PBUS_DMA_MASK (default channel 1), `buf_dir_n` goes low on the clock that samples that `dack_n` bit falling, and high on the clock that samples it rising. Unmarked channels leave it unchanged.
- R10: `buf_oe_n` goes low on the clock that samples a command falling edge only if the address hits an enabled device. An I/O command must hit 0060h, 0062h, 0064h, 0066h, 0070h or 0071h with that device's enable bit set; a memory command must produce an enabled ROM hit. With the enable bit cleared, no output enable is produced.
- R11: When the cycle was opened with `ext_master` low, `buf_oe_n` returns high on the clock that samples any command rising edge.
- R12: When the cycle was opened with `ext_master` high, `buf_oe_n` stays low after the command ends. It returns high on the clock that samples an address that hits no enabled device.
- R13: When `gpo_mode[i]` is set, the output at index i follows `gpo_val[i]`. The index order is 0 kbc_cs_n, 1 mc_cs_n, 2 rtc_cs_n, 3 rom_cs_n, 4 rtc_ale, 5 buf_oe_n, 6 buf_dir_n.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock; commands and acknowledges are sampled on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset; forces all outputs idle |
| addr | input | ADDR_W (24) | Bus address; I/O decodes use bits [15:0] |
| ior_n | input | 1 | I/O read command, active low |
| iow_n | input | 1 | I/O write command, active low |
| memr_n | input | 1 | Memory read command, active low |
| memw_n | input | 1 | Memory write command, active low |
| dack_n | input | NUM_DMA (4) | DMA acknowledges, active low |
| ext_master | input | 1 | High when an external bus master owns the cycle |
| sys_tick | input | 1 | One-cycle pulse per system-bus clock period |
| dec_en | input | 4 | Decode enables: [0] keyboard, [1] microcontroller, [2] clock, [3] ROM |
| gpo_mode | input | 7 | Per-output general-purpose mode bits |
| gpo_val | input | 7 | Per-output general-purpose values |
| kbc_cs_n | output | 1 | Keyboard controller select, active low |
| mc_cs_n | output | 1 | Microcontroller select, active low |
| rtc_cs_n | output | 1 | Real-time clock data select, active low |
| rom_cs_n | output | 1 | Boot ROM select, active low |
| rtc_ale | output | 1 | Real-time clock address-latch strobe, active high |
| buf_oe_n | output | 1 | Data buffer output enable, active low |
| buf_dir_n | output | 1 | Data buffer direction; low drives peripheral data toward the system bus |

## Verification
On every cycle, the assertions check the following. No two chip selects are low at once. Each rise of the latch strobe follows a start request, and the strobe does not drop in a cycle without a tick. Each fall of the direction control follows a read command or an acknowledge on a marked channel, and a memory-read fall needs a ROM hit. Each opening of the output enable follows an enabled hit, and each closing matches the initiator recorded for the cycle. The bench scenarios are needed for the rest. They show the exact address values that decode, that a disabled device produces nothing, that the strobe length is two ticks, and which cycle each edge takes effect in. They also show the general-purpose takeover and that outputs are idle in reset.

// File: rtl/lbd_pkg.sv
// Package: shared constants for the legacy bus decoder.
// Assumes outputs are indexed in the fixed order given by pin_e.
package lbd_pkg;
    localparam int IO_W      = 16;
    localparam int DEV_CNT   = 4;
    localparam int NUM_PINS  = 7;

    typedef enum logic [2:0] {
        PIN_KBC = 3'd0,
        PIN_MC  = 3'd1,
        PIN_RTC = 3'd2,
        PIN_ROM = 3'd3,
        PIN_ALE = 3'd4,
        PIN_OE  = 3'd5,
        PIN_DIR = 3'd6
    } pin_e;

    // Inactive level of each output: all active-low except the latch strobe.
    localparam logic [NUM_PINS-1:0] PIN_IDLE = 7'b110_1111;

    // Decode-enable bit positions.
    localparam int EN_KBC = 0;
    localparam int EN_MC  = 1;
    localparam int EN_RTC = 2;
    localparam int EN_ROM = 3;
endpackage

// File: rtl/lbd_addr_decode.sv
// Module: lbd_addr_decode
// Purely combinational address decode. It produces the four active-low
// chip selects plus the hit flags used by the buffer controller.
// Assumes I/O decodes look only at the low 16 address bits, and the ROM
// window compares the full address.
module lbd_addr_decode
    import lbd_pkg::*;
#(
    parameter int                 ADDR_W   = 24,
    parameter logic [ADDR_W-1:0]  ROM_LO   = 24'h0E_0000,
    parameter logic [ADDR_W-1:0]  ROM_HI   = 24'h0F_FFFF,
    parameter logic [IO_W-1:0]    KBC_P0   = 16'h0060,
    parameter logic [IO_W-1:0]    KBC_P1   = 16'h0064,
    parameter logic [IO_W-1:0]    MC_P0    = 16'h0062,
    parameter logic [IO_W-1:0]    MC_P1    = 16'h0066,
    parameter logic [IO_W-1:0]    RTC_IDX  = 16'h0070,
    parameter logic [IO_W-1:0]    RTC_DAT  = 16'h0071
) (
    input  logic [ADDR_W-1:0]  addr,
    input  logic               io_cmd,
    input  logic               mem_cmd,
    input  logic               dma_active,
    input  logic [DEV_CNT-1:0] dec_en,
    output logic [DEV_CNT-1:0] cs_n,
    output logic               io_hit_en,
    output logic               rom_hit_en,
    output logic               rom_range,
    output logic               rtc_idx_en
);
    logic [IO_W-1:0] io_addr;
    logic kbc_hit, mc_hit, idx_hit, dat_hit;

    // Address comparisons against the fixed device ports and the ROM window.
    always_comb begin
        io_addr   = addr[IO_W-1:0];
        kbc_hit   = (io_addr == KBC_P0) || (io_addr == KBC_P1);
        mc_hit    = (io_addr == MC_P0)  || (io_addr == MC_P1);
        idx_hit   = (io_addr == RTC_IDX);
        dat_hit   = (io_addr == RTC_DAT);
        rom_range = (addr >= ROM_LO) && (addr <= ROM_HI) && !dma_active;
    end

    // Enabled hit flags, independent of the command that is active.
    always_comb begin
        io_hit_en  = (kbc_hit && dec_en[EN_KBC]) ||
                     (mc_hit  && dec_en[EN_MC])  ||
                     ((idx_hit || dat_hit) && dec_en[EN_RTC]);
        rom_hit_en = rom_range && dec_en[EN_ROM];
        rtc_idx_en = idx_hit && dec_en[EN_RTC];
    end

    // Chip selects qualified by the command type.
    always_comb begin
        cs_n         = '1;
        cs_n[EN_KBC] = !(io_cmd && kbc_hit && dec_en[EN_KBC]);
        cs_n[EN_MC]  = !(io_cmd && mc_hit  && dec_en[EN_MC]);
        cs_n[EN_RTC] = !(io_cmd && dat_hit && dec_en[EN_RTC]);
        cs_n[EN_ROM] = !(mem_cmd && rom_hit_en);
    end
endmodule

// File: rtl/lbd_rtc_strobe.sv
// Module: lbd_rtc_strobe
// Generates the clock-chip address-latch strobe. A start request raises it
// from the next clock, and it is held for TICKS sampled system ticks.
// Assumes start is a one-cycle pulse and sys_tick is one cycle per tick.
module lbd_rtc_strobe #(
    parameter int TICKS   = 2,
    localparam int CNT_W  = $clog2(TICKS + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic sys_tick,
    output logic ale
);
    logic [CNT_W-1:0] ticks_left;

    // Load the tick budget on start, spend one per tick while running.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ticks_left <= '0;
        end else if (start) begin
            ticks_left <= CNT_W'(TICKS);
        end else if (sys_tick && (ticks_left != '0)) begin
            ticks_left <= ticks_left - 1'b1;
        end
    end

    // The strobe is high while budget remains.
    always_comb ale = (ticks_left != '0);

    // R6: the strobe only rises after a start request.
    p_ale_start_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ale) |-> $past(start));

    // R6: the strobe cannot drop in a cycle that samples no tick.
    p_ale_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (ale && !sys_tick) |=> ale);
endmodule

// File: rtl/lbd_xcvr_ctrl.sv
// Module: lbd_xcvr_ctrl
// Registered control of the peripheral data buffer. It detects command and
// acknowledge edges against the previous sample, then opens and closes the
// output enable and the direction control. It also reports the index-write
// edge for the latch strobe. Assumes the strobes are synchronous to clk.
module lbd_xcvr_ctrl #(
    parameter int                NUM_DMA   = 4,
    parameter logic [NUM_DMA-1:0] PBUS_MASK = 4'b0010
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               ior_n,
    input  logic               iow_n,
    input  logic               memr_n,
    input  logic               memw_n,
    input  logic [NUM_DMA-1:0] dack_n,
    input  logic               ext_master,
    input  logic               io_hit_en,
    input  logic               rom_hit_en,
    input  logic               rom_range,
    output logic               iow_fall,
    output logic               oe_n,
    output logic               dir_n
);
    logic               ior_q, iow_q, memr_q, memw_q;
    logic [NUM_DMA-1:0] dack_q;
    logic               ext_q;
    logic ior_fall, memr_fall, memw_fall;
    logic ior_rise, iow_rise, memr_rise, memw_rise;
    logic cmd_rise, dack_fall, dack_rise, dev_sel;

    // Keep the previous sample of every strobe for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ior_q  <= 1'b1;
            iow_q  <= 1'b1;
            memr_q <= 1'b1;
            memw_q <= 1'b1;
            dack_q <= '1;
        end else begin
            ior_q  <= ior_n;
            iow_q  <= iow_n;
            memr_q <= memr_n;
            memw_q <= memw_n;
            dack_q <= dack_n;
        end
    end

    // Edge flags for the commands and the marked acknowledges.
    always_comb begin
        ior_fall  = ior_q  && !ior_n;
        iow_fall  = iow_q  && !iow_n;
        memr_fall = memr_q && !memr_n;
        memw_fall = memw_q && !memw_n;
        ior_rise  = !ior_q  && ior_n;
        iow_rise  = !iow_q  && iow_n;
        memr_rise = !memr_q && memr_n;
        memw_rise = !memw_q && memw_n;
        cmd_rise  = ior_rise || iow_rise || memr_rise || memw_rise;
        dack_fall = |(dack_q & ~dack_n & PBUS_MASK);
        dack_rise = |(~dack_q & dack_n & PBUS_MASK);
        dev_sel   = ((ior_fall || iow_fall) && io_hit_en) ||
                    ((memr_fall || memw_fall) && rom_hit_en);
    end

    // Direction: low for reads toward the system bus, high otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dir_n <= 1'b1;
        end else if (ior_fall || (memr_fall && rom_range) || dack_fall) begin
            dir_n <= 1'b0;
        end else if (ior_rise || memr_rise || dack_rise) begin
            dir_n <= 1'b1;
        end
    end

    // Output enable: opened on an enabled hit, closed per cycle owner.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            oe_n  <= 1'b1;
            ext_q <= 1'b0;
        end else if (dev_sel) begin
            oe_n  <= 1'b0;
            ext_q <= ext_master;
        end else if (!oe_n) begin
            if (ext_q ? !(io_hit_en || rom_hit_en) : cmd_rise) begin
                oe_n <= 1'b1;
            end
        end
    end

    // R1: the first cycle after reset leaves the buffer idle.
    p_reset_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> (oe_n && dir_n));

    // R7: direction only falls after a read strobe or a marked acknowledge.
    p_dir_cause_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(dir_n) |-> ($past(!ior_n) || $past(!memr_n) ||
                          $past(|(~dack_n & PBUS_MASK))));

    // R8: a memory-read fall of direction needs the ROM window.
    p_dir_rom_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(dir_n) && $past(ior_n) && $past(&(dack_n | ~PBUS_MASK)))
        |-> $past(rom_range));

    // R10: the enable only opens on an enabled device hit.
    p_oe_hit_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(oe_n) |-> $past(io_hit_en || rom_hit_en));

    // R11: a bridge-owned enable closes only on a command rise.
    p_oe_bridge_r11: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(oe_n) && !$past(ext_q)) |-> $past(cmd_rise));

    // R12: an external-master enable closes only when decode is lost.
    p_oe_ext_r12: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(oe_n) && $past(ext_q)) |-> $past(!(io_hit_en || rom_hit_en)));
endmodule

// File: rtl/lbd_pin_mux.sv
// Module: lbd_pin_mux
// Per-output selection between the functional value and a general-purpose
// value, with every output forced to its idle level while reset is held.
// Assumes the index order of lbd_pkg::pin_e.
module lbd_pin_mux
    import lbd_pkg::*;
(
    input  logic                rst_n,
    input  logic [NUM_PINS-1:0] func_val,
    input  logic [NUM_PINS-1:0] gpo_mode,
    input  logic [NUM_PINS-1:0] gpo_val,
    output logic [NUM_PINS-1:0] pin_out
);
    for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
        // Reset idles the pin; otherwise the mode bit picks the source.
        always_comb begin
            if (!rst_n) begin
                pin_out[i] = PIN_IDLE[i];
            end else if (gpo_mode[i]) begin
                pin_out[i] = gpo_val[i];
            end else begin
                pin_out[i] = func_val[i];
            end
        end
    end
endmodule

// File: rtl/legacy_bus_decoder.sv
// Module: legacy_bus_decoder (top)
// Decodes legacy I/O and memory cycles into device selects. It also drives
// the peripheral data buffer controls and the clock-chip latch strobe.
// Assumes all bus strobes are synchronous to clk and that sys_tick marks
// each system-bus clock period with a one-cycle pulse.
module legacy_bus_decoder
    import lbd_pkg::*;
#(
    parameter int                 ADDR_W        = 24,
    parameter int                 NUM_DMA       = 4,
    parameter logic [NUM_DMA-1:0] PBUS_DMA_MASK = 4'b0010,
    parameter logic [ADDR_W-1:0]  ROM_LO        = 24'h0E_0000,
    parameter logic [ADDR_W-1:0]  ROM_HI        = 24'h0F_FFFF,
    parameter int                 ALE_TICKS     = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [ADDR_W-1:0]   addr,
    input  logic                ior_n,
    input  logic                iow_n,
    input  logic                memr_n,
    input  logic                memw_n,
    input  logic [NUM_DMA-1:0]  dack_n,
    input  logic                ext_master,
    input  logic                sys_tick,
    input  logic [DEV_CNT-1:0]  dec_en,
    input  logic [NUM_PINS-1:0] gpo_mode,
    input  logic [NUM_PINS-1:0] gpo_val,
    output logic                kbc_cs_n,
    output logic                mc_cs_n,
    output logic                rtc_cs_n,
    output logic                rom_cs_n,
    output logic                rtc_ale,
    output logic                buf_oe_n,
    output logic                buf_dir_n
);
    logic               io_cmd, mem_cmd, dma_active;
    logic [DEV_CNT-1:0] cs_n;
    logic               io_hit_en, rom_hit_en, rom_range, rtc_idx_en;
    logic               iow_fall, ale, oe_n, dir_n;
    logic [NUM_PINS-1:0] func_val, pin_out;

    // Command class and DMA activity summary.
    always_comb begin
        io_cmd     = !ior_n || !iow_n;
        mem_cmd    = !memr_n || !memw_n;
        dma_active = !(&dack_n);
    end

    lbd_addr_decode #(
        .ADDR_W (ADDR_W),
        .ROM_LO (ROM_LO),
        .ROM_HI (ROM_HI)
    ) i_decode (
        .addr       (addr),
        .io_cmd     (io_cmd),
        .mem_cmd    (mem_cmd),
        .dma_active (dma_active),
        .dec_en     (dec_en),
        .cs_n       (cs_n),
        .io_hit_en  (io_hit_en),
        .rom_hit_en (rom_hit_en),
        .rom_range  (rom_range),
        .rtc_idx_en (rtc_idx_en)
    );

    lbd_xcvr_ctrl #(
        .NUM_DMA   (NUM_DMA),
        .PBUS_MASK (PBUS_DMA_MASK)
    ) i_xcvr (
        .clk        (clk),
        .rst_n      (rst_n),
        .ior_n      (ior_n),
        .iow_n      (iow_n),
        .memr_n     (memr_n),
        .memw_n     (memw_n),
        .dack_n     (dack_n),
        .ext_master (ext_master),
        .io_hit_en  (io_hit_en),
        .rom_hit_en (rom_hit_en),
        .rom_range  (rom_range),
        .iow_fall   (iow_fall),
        .oe_n       (oe_n),
        .dir_n      (dir_n)
    );

    lbd_rtc_strobe #(
        .TICKS (ALE_TICKS)
    ) i_strobe (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (iow_fall && rtc_idx_en),
        .sys_tick (sys_tick),
        .ale      (ale)
    );

    // Gather functional values in pin order.
    always_comb begin
        func_val          = '0;
        func_val[PIN_KBC] = cs_n[EN_KBC];
        func_val[PIN_MC]  = cs_n[EN_MC];
        func_val[PIN_RTC] = cs_n[EN_RTC];
        func_val[PIN_ROM] = cs_n[EN_ROM];
        func_val[PIN_ALE] = ale;
        func_val[PIN_OE]  = oe_n;
        func_val[PIN_DIR] = dir_n;
    end

    lbd_pin_mux i_mux (
        .rst_n    (rst_n),
        .func_val (func_val),
        .gpo_mode (gpo_mode),
        .gpo_val  (gpo_val),
        .pin_out  (pin_out)
    );

    // Drive the named outputs from the muxed vector.
    always_comb begin
        kbc_cs_n  = pin_out[PIN_KBC];
        mc_cs_n   = pin_out[PIN_MC];
        rtc_cs_n  = pin_out[PIN_RTC];
        rom_cs_n  = pin_out[PIN_ROM];
        rtc_ale   = pin_out[PIN_ALE];
        buf_oe_n  = pin_out[PIN_OE];
        buf_dir_n = pin_out[PIN_DIR];
    end

    // R2: in functional mode no two chip selects are low together.
    p_cs_exclusive_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (gpo_mode == '0) |-> $onehot0(~{kbc_cs_n, mc_cs_n, rtc_cs_n, rom_cs_n}));

    // R5: the ROM select stays high while any DMA acknowledge is active.
    p_rom_no_dma_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!gpo_mode[PIN_ROM] && !(&dack_n)) |-> rom_cs_n);
endmodule

// File: tb/test_legacy_bus_decoder.sv
module test_legacy_bus_decoder;
    logic        clk = 1'b0;
    logic        rst_n;
    logic [23:0] addr;
    logic        ior_n, iow_n, memr_n, memw_n;
    logic [3:0]  dack_n;
    logic        ext_master, sys_tick;
    logic [3:0]  dec_en;
    logic [6:0]  gpo_mode, gpo_val;
    logic        kbc_cs_n, mc_cs_n, rtc_cs_n, rom_cs_n, rtc_ale, buf_oe_n, buf_dir_n;

    int n_checks = 0;
    int n_errors = 0;
    int cycles   = 0;
    bit done     = 1'b0;

    always #2 clk = ~clk;

    legacy_bus_decoder i_legacy_bus_decoder (
        .clk(clk), .rst_n(rst_n), .addr(addr),
        .ior_n(ior_n), .iow_n(iow_n), .memr_n(memr_n), .memw_n(memw_n),
        .dack_n(dack_n), .ext_master(ext_master), .sys_tick(sys_tick),
        .dec_en(dec_en), .gpo_mode(gpo_mode), .gpo_val(gpo_val),
        .kbc_cs_n(kbc_cs_n), .mc_cs_n(mc_cs_n), .rtc_cs_n(rtc_cs_n),
        .rom_cs_n(rom_cs_n), .rtc_ale(rtc_ale), .buf_oe_n(buf_oe_n),
        .buf_dir_n(buf_dir_n)
    );

    // Vector: address, commands {ior,iow,memr,memw}, dma flag, enables,
    // expected selects {kbc,mc,rtc,rom}, requirement number.
    typedef struct packed {
        logic [23:0] a;
        logic [3:0]  cmd_n;
        logic        dma;
        logic [3:0]  en;
        logic [3:0]  exp_cs_n;
        logic [7:0]  req;
    } vec_t;

    localparam int NVEC = 16;
    localparam vec_t VECS [NVEC] = '{
        '{24'h000060, 4'b0111, 1'b0, 4'hF, 4'b0111, 8'd2},  // R2 read 60h
        '{24'h000064, 4'b1011, 1'b0, 4'hF, 4'b0111, 8'd2},  // R2 write 64h
        '{24'h000062, 4'b0111, 1'b0, 4'hF, 4'b1011, 8'd3},  // R3 read 62h
        '{24'h000066, 4'b1011, 1'b0, 4'hF, 4'b1011, 8'd3},  // R3 write 66h
        '{24'h000071, 4'b0111, 1'b0, 4'hF, 4'b1101, 8'd4},  // R4 data port
        '{24'h000070, 4'b1011, 1'b0, 4'hF, 4'b1111, 8'd4},  // R4 index port no select
        '{24'h000060, 4'b1111, 1'b0, 4'hF, 4'b1111, 8'd2},  // R2 no command
        '{24'h000060, 4'b1101, 1'b0, 4'hF, 4'b1111, 8'd2},  // R2 memory cmd ignored
        '{24'h0E0000, 4'b1101, 1'b0, 4'hF, 4'b1110, 8'd5},  // R5 ROM low edge
        '{24'h0FFFFF, 4'b1110, 1'b0, 4'hF, 4'b1110, 8'd5},  // R5 ROM high edge
        '{24'h0DFFFF, 4'b1101, 1'b0, 4'hF, 4'b1111, 8'd5},  // R5 below window
        '{24'h0E0000, 4'b1101, 1'b1, 4'hF, 4'b1111, 8'd5},  // R5 during DMA
        '{24'h000060, 4'b0111, 1'b0, 4'hE, 4'b1111, 8'd2},  // R2 keyboard disabled
        '{24'h0E0000, 4'b1101, 1'b0, 4'h7, 4'b1111, 8'd5},  // R5 ROM disabled
        '{24'h001060, 4'b0111, 1'b0, 4'hF, 4'b1111, 8'd2},  // R2 full 16-bit compare
        '{24'h100060, 4'b0111, 1'b0, 4'hF, 4'b0111, 8'd2}   // R2 upper bits ignored
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic idle_bus();
        ior_n = 1'b1; iow_n = 1'b1; memr_n = 1'b1; memw_n = 1'b1;
        dack_n = 4'hF; sys_tick = 1'b0;
    endtask

    function automatic logic [6:0] pins();
        return {buf_dir_n, buf_oe_n, rtc_ale, rom_cs_n, rtc_cs_n, mc_cs_n, kbc_cs_n};
    endfunction

    // Watchdog: a hung run counts as a failure and still reports.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000 && !done) begin
            n_errors++;
            n_checks++;
            $display("FAIL R0 watchdog: actual=%0d expected=<20000 cycles", cycles);
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; addr = 24'h000060; ext_master = 1'b0;
        dec_en = 4'hF; gpo_mode = '0; gpo_val = '0;
        idle_bus();
        ior_n = 1'b0;
        repeat (3) @(negedge clk);
        #1 chk("R1 idle in reset with active read", 32'(pins()), 32'h6F);
        @(negedge clk);
        ior_n = 1'b1; addr = 24'h000300;
        rst_n = 1'b1;
        @(negedge clk);
        #1 chk("R1 idle after reset", 32'(pins()), 32'h6F);

        // Table walk over the combinational decode.
        for (int i = 0; i < NVEC; i++) begin
            @(negedge clk);
            addr   = VECS[i].a;
            {ior_n, iow_n, memr_n, memw_n} = VECS[i].cmd_n;
            dack_n = VECS[i].dma ? 4'b1110 : 4'hF;
            dec_en = VECS[i].en;
            #1 chk($sformatf("R%0d vector %0d selects", VECS[i].req, i),
                   32'({kbc_cs_n, mc_cs_n, rtc_cs_n, rom_cs_n}), 32'(VECS[i].exp_cs_n));
        end
        @(negedge clk);
        idle_bus(); dec_en = 4'hF; addr = 24'h000300;
        repeat (3) @(negedge clk);
        #1 chk("R11 buffer idle after table", 32'({buf_oe_n, buf_dir_n}), 32'h3);

        // R6 latch strobe on an index write, two ticks long.
        @(negedge clk); addr = 24'h000070; iow_n = 1'b0;
        @(negedge clk); #1 chk("R6 strobe starts", 32'(rtc_ale), 32'h1);
        iow_n = 1'b1;
        repeat (3) @(negedge clk);
        #1 chk("R6 strobe held without ticks", 32'(rtc_ale), 32'h1);
        sys_tick = 1'b1;
        @(negedge clk); sys_tick = 1'b0;
        #1 chk("R6 strobe after one tick", 32'(rtc_ale), 32'h1);
        sys_tick = 1'b1;
        @(negedge clk); sys_tick = 1'b0;
        #1 chk("R6 strobe ends after second tick", 32'(rtc_ale), 32'h0);
        addr = 24'h000071; iow_n = 1'b0;
        @(negedge clk); #1 chk("R6 data-port write no strobe", 32'(rtc_ale), 32'h0);
        iow_n = 1'b1; dec_en = 4'b1011;
        @(negedge clk); addr = 24'h000070; iow_n = 1'b0;
        @(negedge clk); #1 chk("R6 disabled clock no strobe", 32'(rtc_ale), 32'h0);
        iow_n = 1'b1; dec_en = 4'hF;
        repeat (2) @(negedge clk);

        // R7 direction on an undecoded I/O read.
        addr = 24'h000300; ior_n = 1'b0;
        @(negedge clk); #1 chk("R7 dir low on read", 32'(buf_dir_n), 32'h0);
        ior_n = 1'b1;
        @(negedge clk); #1 chk("R7 dir high after read", 32'(buf_dir_n), 32'h1);

        // R8 direction on memory reads.
        addr = 24'h0E1234; memr_n = 1'b0;
        @(negedge clk); #1 chk("R8 dir low on ROM read", 32'(buf_dir_n), 32'h0);
        memr_n = 1'b1;
        @(negedge clk); #1 chk("R8 dir high after ROM read", 32'(buf_dir_n), 32'h1);
        addr = 24'h010000; memr_n = 1'b0;
        @(negedge clk); #1 chk("R8 dir stays high off ROM", 32'(buf_dir_n), 32'h1);
        memr_n = 1'b1;
        @(negedge clk);

        // R9 direction follows marked acknowledge only.
        dack_n = 4'b1101;
        @(negedge clk); #1 chk("R9 dir low on marked ack", 32'(buf_dir_n), 32'h0);
        dack_n = 4'hF;
        @(negedge clk); #1 chk("R9 dir high on ack release", 32'(buf_dir_n), 32'h1);
        dack_n = 4'b1110;
        @(negedge clk); #1 chk("R9 unmarked ack ignored", 32'(buf_dir_n), 32'h1);
        dack_n = 4'hF;
        @(negedge clk);

        // R10 and R11 bridge-owned cycle.
        addr = 24'h000060; ior_n = 1'b0;
        @(negedge clk); #1 chk("R10 oe low on enabled hit", 32'(buf_oe_n), 32'h0);
        ior_n = 1'b1;
        @(negedge clk); #1 chk("R11 oe high at command end", 32'(buf_oe_n), 32'h1);
        dec_en = 4'b1110; ior_n = 1'b0;
        @(negedge clk); #1 chk("R10 disabled device no oe", 32'(buf_oe_n), 32'h1);
        ior_n = 1'b1; dec_en = 4'hF;
        @(negedge clk); addr = 24'h000300; iow_n = 1'b0;
        @(negedge clk); #1 chk("R10 undecoded address no oe", 32'(buf_oe_n), 32'h1);
        iow_n = 1'b1;
        @(negedge clk);

        // R12 external-master cycle.
        ext_master = 1'b1; addr = 24'h000064; iow_n = 1'b0;
        @(negedge clk); #1 chk("R12 oe low for master", 32'(buf_oe_n), 32'h0);
        iow_n = 1'b1;
        repeat (2) @(negedge clk);
        #1 chk("R12 oe held while decoded", 32'(buf_oe_n), 32'h0);
        addr = 24'h000300;
        @(negedge clk); #1 chk("R12 oe high when decode lost", 32'(buf_oe_n), 32'h1);
        ext_master = 1'b0;

        // R13 general-purpose takeover.
        gpo_mode = 7'h7F; gpo_val = 7'b1010101;
        @(negedge clk); #1 chk("R13 all pins from values", 32'(pins()), 32'h55);
        gpo_mode = 7'b1000000; gpo_val = 7'b0000000;
        @(negedge clk); #1 chk("R13 dir pin only", 32'(pins()), 32'h2F);
        gpo_mode = '0;

        // R1 reset mid-run with an active cycle.
        addr = 24'h000062; ior_n = 1'b0; rst_n = 1'b0;
        #1 chk("R1 idle when reset asserted", 32'(pins()), 32'h6F);
        @(negedge clk); ior_n = 1'b1; addr = 24'h000300;
        rst_n = 1'b1;
        @(negedge clk); #1 chk("R1 registered state idle", 32'(pins()), 32'h6F);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end
endmodule